// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table held in memory. A requester hands over one translation at a time: the virtual address and the kind of access (load, store or instruction fetch). The page table root address comes in as a plain control input and is captured when the request is accepted.

The walker reads the first-level (directory) word, then the second-level (table) word, through a single word-wide memory port. It checks the valid and permission bits and answers with the physical address and the page's permission bits, or with a fault code. When a store reaches a page whose dirty flag is still clear, the walker writes the table word back with the dirty flag set before it answers.

Request, response and memory command each use a valid/ready handshake. A transfer happens on a clock edge where both valid and ready are high. A sender that raises valid keeps valid and its payload unchanged until ready is seen, so either side may apply back-pressure for any number of cycles. Read data returns on its own strobe, which has no ready.

Top module: `pt_walk_engine`

## Requirements
- R1: `req_ready` is high only when no walk is in progress, and it drops in the cycle after a request is accepted, so at most one walk is outstanding.
- R2: The first memory command of a walk is a read of address `root_base + 4 * vaddr[31:22]`. `root_base` is sampled when the request is accepted.
- R3: When the directory word has bit 0 set, the second command is a read of address `{dir_word[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: A successful walk answers with status 2'b00, physical address `{tbl_word[31:12], vaddr[11:0]}` and `rsp_perm = {tbl_word[3], tbl_word[2], tbl_word[1]}` (execute, write, read).
- R5: A directory word with bit 0 clear ends the walk with status 2'b01 (page fault), physical address 0 and permissions 0. No further memory command is issued.
- R6: A table word with bit 0 clear ends the walk with status 2'b01, physical address 0 and permissions 0.
- R7: Access kind 2'b00 (load) and 2'b11 need table bit 1. Kind 2'b01 (store) needs bit 2. Kind 2'b10 (fetch) needs bit 3. A missing bit ends the walk with status 2'b10 (protection fault), address 0, permissions 0 and no write.
- R8: A permitted store whose table word has bit 4 (dirty) clear issues exactly one write to the table word's address before the response. The write data is the table word with bit 4 set and all other bits, reserved ones included, unchanged.
- R9: A permitted store whose table word already has bit 4 set issues no write.
- R10: While `mem_valid` is high and `mem_ready` low, the memory command stays unchanged. While `rsp_valid` is high and `rsp_ready` low, the response stays unchanged.
- R11: During and right after reset, `req_ready` is 1 and `mem_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_base | input | 32 | Physical address of the directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_perm | output | 3 | Execute, write, read bits of the page |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory accepts the command |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word address of the command |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
On every cycle the assertions check the handshake rules: commands and results held under back-pressure, one walk at a time, no memory command while a result waits, writes only for stores, the offset carried into the address, and zero addresses on faults. The bench's scenarios cover what depends on table contents: the address of each level, which bit decides each access kind, whether the dirty write-back happens, pass-through of reserved bits, and capture of the root at acceptance. A behavioural model predicts the exact sequence of memory commands and the result of every walk, under varied memory stalls and read latencies.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_PAGE  = 2'b01,
    ST_PROT  = 2'b10
  } walk_status_e;

  typedef enum logic [2:0] {
    W_IDLE, W_DIR_RD, W_DIR_WT, W_TBL_RD, W_TBL_WT, W_CHECK, W_WB, W_RESP
  } walk_state_e;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_D = 4;
endpackage

// File: rtl/pt_addr_form.sv
module pt_addr_form #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW = 2 * IDX_W + OFF_W
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] dir_word,
  output logic [AW-1:0] dir_addr,
  output logic [AW-1:0] tbl_addr
);
  localparam int PPN_W = AW - OFF_W;

  logic [IDX_W-1:0] dir_idx, tbl_idx;
  assign dir_idx = vaddr[AW-1 -: IDX_W];
  assign tbl_idx = vaddr[OFF_W +: IDX_W];

  assign dir_addr = base + AW'({dir_idx, 2'b00});
  assign tbl_addr = {dir_word[AW-1 -: PPN_W], {OFF_W{1'b0}}} + AW'({tbl_idx, 2'b00});
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walk_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic [EW-1:0] entry,
  input  acc_kind_e     kind,
  output logic          present,
  output logic          permitted,
  output logic          needs_dirty,
  output logic [EW-1:0] dirty_entry
);
  assign present = entry[BIT_V];

  always_comb begin
    unique case (kind)
      ACC_STORE: permitted = entry[BIT_W];
      ACC_FETCH: permitted = entry[BIT_X];
      default:   permitted = entry[BIT_R];
    endcase
  end

  assign needs_dirty = (kind == ACC_STORE) && !entry[BIT_D];
  assign dirty_entry = entry | (EW'(1) << BIT_D);
endmodule

// File: rtl/pt_walk_engine.sv
module pt_walk_engine
  import pt_walk_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int AW = 2 * IDX_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] root_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_status,
  output logic [AW-1:0] rsp_paddr,
  output logic [2:0]    rsp_perm,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  localparam int PPN_W = AW - OFF_W;

  walk_state_e   st;
  logic [AW-1:0] vaddr_q, base_q, dir_q, tbl_q;
  acc_kind_e     kind_q;
  logic [AW-1:0] dir_addr, tbl_addr, dirty_word;
  logic          present, permitted, needs_dirty;

  pt_addr_form #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .vaddr(vaddr_q), .base(base_q), .dir_word(dir_q),
    .dir_addr(dir_addr), .tbl_addr(tbl_addr)
  );

  pt_entry_check #(.EW(AW)) u_check (
    .entry(tbl_q), .kind(kind_q), .present(present), .permitted(permitted),
    .needs_dirty(needs_dirty), .dirty_entry(dirty_word)
  );

  assign req_ready = (st == W_IDLE);
  assign rsp_valid = (st == W_RESP);
  assign mem_valid = (st == W_DIR_RD) || (st == W_TBL_RD) || (st == W_WB);
  assign mem_write = (st == W_WB);
  assign mem_addr  = (st == W_DIR_RD) ? dir_addr : tbl_addr;
  assign mem_wdata = (st == W_WB) ? dirty_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      vaddr_q    <= '0;
      base_q     <= '0;
      dir_q      <= '0;
      tbl_q      <= '0;
      kind_q     <= ACC_LOAD;
      rsp_status <= ST_OK;
      rsp_paddr  <= '0;
      rsp_perm   <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          kind_q  <= acc_kind_e'(req_kind);
          base_q  <= root_base;
          st      <= W_DIR_RD;
        end
        W_DIR_RD: if (mem_ready) st <= W_DIR_WT;
        W_DIR_WT: if (mem_rvalid) begin
          dir_q <= mem_rdata;
          if (!mem_rdata[BIT_V]) begin
            rsp_status <= ST_PAGE;
            rsp_paddr  <= '0;
            rsp_perm   <= '0;
            st         <= W_RESP;
          end else begin
            st <= W_TBL_RD;
          end
        end
        W_TBL_RD: if (mem_ready) st <= W_TBL_WT;
        W_TBL_WT: if (mem_rvalid) begin
          tbl_q <= mem_rdata;
          st    <= W_CHECK;
        end
        W_CHECK: begin
          if (!present || !permitted) begin
            rsp_status <= present ? ST_PROT : ST_PAGE;
            rsp_paddr  <= '0;
            rsp_perm   <= '0;
            st         <= W_RESP;
          end else begin
            rsp_status <= ST_OK;
            rsp_paddr  <= {tbl_q[AW-1 -: PPN_W], vaddr_q[OFF_W-1:0]};
            rsp_perm   <= {tbl_q[BIT_X], tbl_q[BIT_W], tbl_q[BIT_R]};
            st         <= needs_dirty ? W_WB : W_RESP;
          end
        end
        W_WB:   if (mem_ready) st <= W_RESP;
        W_RESP: if (rsp_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) &&
                                   $stable(rsp_paddr) && $stable(rsp_perm)));

  assert_one_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_quiet_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_valid);

  assert_write_only_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (kind_q == ACC_STORE && mem_wdata[BIT_D]));

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_OK) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_OK) |-> (rsp_paddr == '0 && rsp_perm == '0));
endmodule

// File: tb/pt_walk_engine_test.sv
module pt_walk_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] root_base = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic        mem_valid;
  logic        mem_ready = 0;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  pt_walk_engine uut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int bad = 0;
  int cyc = 0;

  // behavioural memory and reference model state
  logic [31:0] mem_m [logic [31:0]];
  logic [64:0] exp_ops [$];   // {write, addr, data}
  logic [1:0]  exp_status;
  logic [31:0] exp_paddr;
  logic [2:0]  exp_perm;
  string       cur_tag = "";
  bit          busy_m = 0;
  bit          got_rsp = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_data = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_m(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return 32'h0;
  endfunction

  // predict the command sequence and result of one walk
  task automatic predict(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] base);
    logic [31:0] da, de, ta, te;
    bit allowed;
    exp_ops.delete();
    da = base + {20'h0, va[31:22], 2'b00};
    exp_ops.push_back({1'b0, da, 32'h0});
    de = rd_m(da);
    exp_status = 2'b01; exp_paddr = 0; exp_perm = 0;
    if (de[0]) begin
      ta = {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      exp_ops.push_back({1'b0, ta, 32'h0});
      te = rd_m(ta);
      if (te[0]) begin
        case (kind)
          2'b01:   allowed = te[2];
          2'b10:   allowed = te[3];
          default: allowed = te[1];
        endcase
        if (!allowed) exp_status = 2'b10;
        else begin
          exp_status = 2'b00;
          exp_paddr  = {te[31:12], va[11:0]};
          exp_perm   = {te[3], te[2], te[1]};
          if (kind == 2'b01 && !te[4]) exp_ops.push_back({1'b1, ta, te | 32'h10});
        end
      end
    end
  endtask

  // memory responder and response monitor, a little after each falling edge
  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (busy_m && req_ready)
        check(0, "R1", "req_ready while a walk is open", 1, 0);
      mem_rvalid = 0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin mem_rvalid = 1; mem_rdata = pend_data; end
      end
      mem_ready = (cyc % 4) != 3;
      if (mem_valid && mem_ready) begin
        if (exp_ops.size() == 0) begin
          check(0, cur_tag, "unexpected memory command addr", mem_addr, 0);
        end else begin
          logic [64:0] e;
          e = exp_ops.pop_front();
          check(mem_write == e[64], cur_tag, "command kind", mem_write, e[64]);
          check(mem_addr == e[63:32], cur_tag, "command address", mem_addr, e[63:32]);
          if (e[64]) check(mem_wdata == e[31:0], cur_tag, "write data", mem_wdata, e[31:0]);
        end
        if (mem_write) mem_m[mem_addr] = mem_wdata;
        else begin pend_data = rd_m(mem_addr); pend_cnt = 1 + (cyc % 3); end
      end
      if (rsp_valid && rsp_ready) begin
        check(rsp_status == exp_status, cur_tag, "status", rsp_status, exp_status);
        check(rsp_paddr == exp_paddr, cur_tag, "physical address", rsp_paddr, exp_paddr);
        check(rsp_perm == exp_perm, cur_tag, "permissions", rsp_perm, exp_perm);
        check(exp_ops.size() == 0, cur_tag, "missing memory commands", exp_ops.size(), 0);
        busy_m = 0;
        got_rsp = 1;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [1:0] kind,
                      input logic [31:0] base, input bit stall, input string tag);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    predict(va, kind, base);
    root_base = base;
    rsp_ready = !stall;
    req_vaddr = va; req_kind = kind; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    busy_m = 1;
    root_base = 32'hDEAD_0000;   // R2: only the value at acceptance counts
    if (stall) begin
      while (!rsp_valid) @(negedge clk);
      repeat (3) begin
        @(negedge clk);
        check(rsp_valid == 1, "R10", "result dropped under back-pressure", rsp_valid, 1);
      end
      rsp_ready = 1;
    end
    while (!got_rsp) @(negedge clk);
    got_rsp = 0;
    @(negedge clk);
  endtask

  initial begin
    mem_m[32'h1000_5718] = 32'h1234_5001;   // directory slot 0x1C6
    mem_m[32'h1234_54A8] = 32'h1481_7007;   // v r w, clean
    mem_m[32'h1234_5004] = 32'h2222_A00B;   // v r x
    mem_m[32'h1234_5008] = 32'h3333_3009;   // v x
    mem_m[32'h1234_500C] = 32'h0000_0000;   // invalid
    mem_m[32'h1234_5010] = 32'hABCD_EFE7;   // v r w, reserved bits set
    mem_m[32'h2000_0718] = 32'h4000_0001;
    mem_m[32'h4000_04A8] = 32'h5555_501F;   // all set, already dirty

    repeat (3) @(negedge clk);
    check(req_ready == 1 && mem_valid == 0 && rsp_valid == 0, "R11", "state in reset",
          {req_ready, mem_valid, rsp_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1 && mem_valid == 0 && rsp_valid == 0, "R11", "state after reset",
          {req_ready, mem_valid, rsp_valid}, 3'b100);

    walk(32'h7192_A44C, 2'b01, 32'h1000_5000, 0, "R2 R3 R4 R8 store clean");
    walk(32'h7192_A44C, 2'b01, 32'h1000_5000, 0, "R9 store dirty");
    walk(32'h7192_A44C, 2'b00, 32'h1000_5000, 0, "R4 load");
    walk(32'h7192_A44C, 2'b10, 32'h1000_5000, 0, "R7 fetch no x");
    walk(32'h7180_1ABC, 2'b01, 32'h1000_5000, 0, "R7 store no w");
    walk(32'h7180_1ABC, 2'b10, 32'h1000_5000, 0, "R4 fetch ok");
    walk(32'h7180_2010, 2'b00, 32'h1000_5000, 0, "R7 load no r");
    walk(32'h7180_2010, 2'b11, 32'h1000_5000, 0, "R7 kind 11 as load");
    walk(32'h7180_2010, 2'b10, 32'h1000_5000, 0, "R7 fetch on x only");
    walk(32'h7180_3FFF, 2'b00, 32'h1000_5000, 0, "R6 table invalid");
    walk(32'h0000_0123, 2'b01, 32'h1000_5000, 0, "R5 directory invalid");
    walk(32'h7180_4008, 2'b01, 32'h1000_5000, 1, "R8 R10 reserved bits kept");
    walk(32'h7192_A44C, 2'b01, 32'h2000_0000, 0, "R2 R9 other root");
    check(mem_m[32'h1234_5010] == 32'hABCD_EFF7, "R8", "stored table word",
          mem_m[32'h1234_5010], 32'hABCD_EFF7);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule